// File: doc/BRIEF.md
# Integer instruction control decoder with custom load

This block sits in the decode stage of a 32-bit integer pipeline. It compares the fetched instruction word against opcode, funct3 and funct7 patterns. From the match it builds a combinational control bundle with these fields:

- legality, plus flags for conditional branch, direct jump, register jump and fence
- read enables for both source registers and a destination write enable
- selects for the two ALU operands and for the immediate format
- an ALU function code
- a memory enable with a read or write command
- a CSR command

Any word that matches nothing produces an all-zero bundle, so it causes no side effects. Opcode 0011111 is accepted as an extra load that behaves exactly like a byte load.

The block also carries the memory access size and signedness of the decoded word through three registered stages: execute, memory and writeback. Each stage has a valid bit and a per-stage stall, and a shared flush clears all valid bits. Floating point, atomics, multiply/divide and coprocessor paths are outside the block.

Top module: `icd_ctrl_decode`

## Requirements
- R1: A conditional branch (opcode 1100011) sets branch, both source reads, op1 = RS1 (code 1), op2 = RS2 (code 1) and imm = B (code 3). It leaves the destination write low.
- R2: The branch compare code depends on funct3 (bits 14:12): 000 gives EQ (10), 001 gives NE (11), 100 gives SLT (3), 101 gives GE (12), 110 gives SLTU (4) and 111 gives GEU (13). funct3 010 and 011 are illegal.
- R3: JAL (1101111) sets jal, op1 = PC (2), op2 = ISZ (instruction size, 3), imm = J (5), ALU ADD (0) and the destination write. JALR (1100111, funct3 000) sets jalr, the rs1 read, op1 = RS1, op2 = IMM (2), imm = I (1), ADD and the destination write.
- R4: LUI (0110111) selects op1 = ZERO (0) and AUIPC (0010111) selects op1 = PC. Both use op2 = IMM, imm = U (4), ADD and the destination write.
- R5: A load (0000011, funct3 000/001/010/100/101) reads rs1 and uses op2 = IMM, imm = I and ADD. It sets the memory enable with command READ (1) and writes rd. A store (0100011, funct3 000/001/010) reads rs1 and rs2 and uses imm = S (2) with command WRITE (2). A store does not write rd.
- R6: Opcode 0011111 with funct3 000 decodes the same as a byte load. With any other funct3 it is illegal.
- R7: Register-register ALU operations (0110011) and immediate ALU operations (0010011) write rd and read rs1. Register-register operations also read rs2 with op2 = RS2 and imm = NONE (0). Immediate operations use op2 = IMM and imm = I. The ALU codes are ADD 0, SUB 1, SLL 2, SLT 3, SLTU 4, XOR 5, SRL 6, SRA 7, OR 8, AND 9. SUB and SRA need funct7 0100000, and the others need funct7 0000000.
- R8: Opcode 1110011 with funct3 001/010/011 reads rs1 and selects op1 = RS1 and op2 = ZERO. With funct3 101/110/111 it selects op1 = ZERO, op2 = IMM and imm = Z (6). Both forms write rd with ADD. The CSR command comes from funct3[1:0]: 01 gives WRITE (1), 10 gives SET (2) and 11 gives CLEAR (3).
- R9: The words 0x00000073, 0x00100073, 0x30200073 and 0x10500073 are legal and carry CSR command INSN (4) with every other field zero. FENCE (0001111, funct3 000) is legal and sets only the fence flag.
- R10: Any other word drives legal low and every other control field to zero.
- R11: On a clock edge where the execute stage is not stalled, it captures size = bits 13:12, signed = NOT bit 14, and valid = id_valid.
- R12: On an edge where a stage is not stalled, the memory stage and then the writeback stage take the previous stage's valid, size and signed values. A stalled stage holds all of its values.
- R13: Reset clears every stage. Flush clears all three valid bits on the next edge, whatever the stalls are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Instruction word is valid |
| id_inst | input | 32 | Instruction word |
| stall | input | 3 | Stall per stage: bit 0 execute, bit 1 memory, bit 2 writeback |
| flush | input | 1 | Clear all stage valid bits |
| dec_legal | output | 1 | Word matched a pattern |
| dec_branch | output | 1 | Conditional branch |
| dec_jal | output | 1 | Direct jump |
| dec_jalr | output | 1 | Register jump |
| dec_rd_rs1 | output | 1 | Reads rs1 |
| dec_rd_rs2 | output | 1 | Reads rs2 |
| dec_wr_rd | output | 1 | Writes rd |
| dec_op1_sel | output | 2 | Operand-1 select |
| dec_op2_sel | output | 2 | Operand-2 select |
| dec_imm_sel | output | 3 | Immediate format |
| dec_alu_fn | output | 4 | ALU function |
| dec_mem_en | output | 1 | Memory access |
| dec_mem_cmd | output | 2 | Memory command |
| dec_csr_cmd | output | 3 | CSR command |
| dec_fence | output | 1 | Fence |
| ex_valid | output | 1 | Execute stage valid |
| ex_size | output | 2 | Execute stage access size |
| ex_signed | output | 1 | Execute stage signed flag |
| mem_valid | output | 1 | Memory stage valid |
| mem_size | output | 2 | Memory stage access size |
| mem_signed | output | 1 | Memory stage signed flag |
| wb_valid | output | 1 | Writeback stage valid |
| wb_size | output | 2 | Writeback stage access size |
| wb_signed | output | 1 | Writeback stage signed flag |

## Verification
Several properties are checked on every cycle:

- an illegal word never carries side effects
- branches and stores never write rd
- the custom load always decodes as a read
- size and sign are captured into execute and then advance one stage per unstalled edge
- a stalled writeback stage holds
- a flush empties every stage

Only the bench scenarios can show the full field values of each instruction class, such as the branch compare mapping and the CSR command per funct3. They also show that near-miss encodings, for example a wrong funct7 or funct3, are rejected, and how stall and flush patterns interleave over long runs.

// File: rtl/icd_pkg.sv
package icd_pkg;
  localparam int ILEN   = 32;
  localparam int NSTAGE = 3;
  localparam int SZ_W   = 2;
  localparam int PAY_W  = SZ_W + 1;
  localparam int OPC_W  = 7;
  localparam int F3_W   = 3;
  localparam int F7_W   = 7;

  typedef enum logic [1:0] {OP1_ZERO = 2'd0, OP1_RS1 = 2'd1, OP1_PC = 2'd2} op1_e;
  typedef enum logic [1:0] {OP2_ZERO = 2'd0, OP2_RS2 = 2'd1, OP2_IMM = 2'd2, OP2_ISZ = 2'd3} op2_e;
  typedef enum logic [2:0] {IMM_NONE = 3'd0, IMM_I = 3'd1, IMM_S = 3'd2, IMM_B = 3'd3,
                            IMM_U = 3'd4, IMM_J = 3'd5, IMM_Z = 3'd6} imm_e;
  typedef enum logic [3:0] {ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_SLL = 4'd2, ALU_SLT = 4'd3,
                            ALU_SLTU = 4'd4, ALU_XOR = 4'd5, ALU_SRL = 4'd6, ALU_SRA = 4'd7,
                            ALU_OR = 4'd8, ALU_AND = 4'd9, ALU_EQ = 4'd10, ALU_NE = 4'd11,
                            ALU_GE = 4'd12, ALU_GEU = 4'd13} alu_e;
  typedef enum logic [1:0] {MC_NONE = 2'd0, MC_READ = 2'd1, MC_WRITE = 2'd2} mcmd_e;
  typedef enum logic [2:0] {CS_NONE = 3'd0, CS_WRITE = 3'd1, CS_SET = 3'd2, CS_CLEAR = 3'd3,
                            CS_INSN = 3'd4} csr_e;

  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_XLOAD  = 7'b0011111;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_ARI_I  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_ARI_R  = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_FENCE  = 7'b0001111;
  localparam logic [OPC_W-1:0] OPC_SYSTEM = 7'b1110011;

  localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

  localparam logic [ILEN-1:0] W_ENV_CALL  = 32'h0000_0073;
  localparam logic [ILEN-1:0] W_ENV_BREAK = 32'h0010_0073;
  localparam logic [ILEN-1:0] W_TRAP_RET  = 32'h3020_0073;
  localparam logic [ILEN-1:0] W_WAIT_INT  = 32'h1050_0073;

  typedef struct packed {
    logic  legal;
    logic  branch;
    logic  jal;
    logic  jalr;
    logic  rd_rs1;
    logic  rd_rs2;
    logic  wr_rd;
    op1_e  op1;
    op2_e  op2;
    imm_e  imm;
    alu_e  alu;
    logic  mem_en;
    mcmd_e mem_cmd;
    csr_e  csr;
    logic  fence;
  } ctrl_t;
endpackage

// File: rtl/icd_decoder.sv
module icd_decoder
  import icd_pkg::*;
(
  input  logic [ILEN-1:0] inst,
  output ctrl_t           ctl
);
  logic [OPC_W-1:0] opc;
  logic [F3_W-1:0]  f3;
  logic [F7_W-1:0]  f7;
  ctrl_t            c;
  logic             ok;

  assign opc = inst[OPC_W-1:0];
  assign f3  = inst[14:12];
  assign f7  = inst[31:25];

  function automatic alu_e base_alu(input logic [F3_W-1:0] f);
    case (f)
      3'b000:  return ALU_ADD;
      3'b001:  return ALU_SLL;
      3'b010:  return ALU_SLT;
      3'b011:  return ALU_SLTU;
      3'b100:  return ALU_XOR;
      3'b101:  return ALU_SRL;
      3'b110:  return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction

  always_comb begin
    c  = '0;
    ok = 1'b0;
    case (opc)
      OPC_LUI, OPC_AUIPC: begin
        ok      = 1'b1;
        c.wr_rd = 1'b1;
        c.op1   = (opc == OPC_LUI) ? OP1_ZERO : OP1_PC;
        c.op2   = OP2_IMM;
        c.imm   = IMM_U;
        c.alu   = ALU_ADD;
      end
      OPC_JAL: begin
        ok      = 1'b1;
        c.jal   = 1'b1;
        c.wr_rd = 1'b1;
        c.op1   = OP1_PC;
        c.op2   = OP2_ISZ;
        c.imm   = IMM_J;
        c.alu   = ALU_ADD;
      end
      OPC_JALR: begin
        ok       = (f3 == 3'b000);
        c.jalr   = 1'b1;
        c.rd_rs1 = 1'b1;
        c.wr_rd  = 1'b1;
        c.op1    = OP1_RS1;
        c.op2    = OP2_IMM;
        c.imm    = IMM_I;
        c.alu    = ALU_ADD;
      end
      OPC_BRANCH: begin
        ok       = (f3[2:1] != 2'b01);
        c.branch = 1'b1;
        c.rd_rs1 = 1'b1;
        c.rd_rs2 = 1'b1;
        c.op1    = OP1_RS1;
        c.op2    = OP2_RS2;
        c.imm    = IMM_B;
        case (f3)
          3'b000:  c.alu = ALU_EQ;
          3'b001:  c.alu = ALU_NE;
          3'b100:  c.alu = ALU_SLT;
          3'b101:  c.alu = ALU_GE;
          3'b110:  c.alu = ALU_SLTU;
          default: c.alu = ALU_GEU;
        endcase
      end
      OPC_LOAD, OPC_XLOAD: begin
        if (opc == OPC_XLOAD) ok = (f3 == 3'b000);
        else ok = (f3 == 3'b000) || (f3 == 3'b001) || (f3 == 3'b010) ||
                  (f3 == 3'b100) || (f3 == 3'b101);
        c.rd_rs1  = 1'b1;
        c.wr_rd   = 1'b1;
        c.op1     = OP1_RS1;
        c.op2     = OP2_IMM;
        c.imm     = IMM_I;
        c.alu     = ALU_ADD;
        c.mem_en  = 1'b1;
        c.mem_cmd = MC_READ;
      end
      OPC_STORE: begin
        ok        = (f3 == 3'b000) || (f3 == 3'b001) || (f3 == 3'b010);
        c.rd_rs1  = 1'b1;
        c.rd_rs2  = 1'b1;
        c.op1     = OP1_RS1;
        c.op2     = OP2_IMM;
        c.imm     = IMM_S;
        c.alu     = ALU_ADD;
        c.mem_en  = 1'b1;
        c.mem_cmd = MC_WRITE;
      end
      OPC_ARI_I: begin
        c.rd_rs1 = 1'b1;
        c.wr_rd  = 1'b1;
        c.op1    = OP1_RS1;
        c.op2    = OP2_IMM;
        c.imm    = IMM_I;
        c.alu    = base_alu(f3);
        if (f3 == 3'b001) ok = (f7 == F7_BASE);
        else if (f3 == 3'b101) begin
          ok = (f7 == F7_BASE) || (f7 == F7_ALT);
          if (f7 == F7_ALT) c.alu = ALU_SRA;
        end else ok = 1'b1;
      end
      OPC_ARI_R: begin
        c.rd_rs1 = 1'b1;
        c.rd_rs2 = 1'b1;
        c.wr_rd  = 1'b1;
        c.op1    = OP1_RS1;
        c.op2    = OP2_RS2;
        c.alu    = base_alu(f3);
        if (f7 == F7_BASE) ok = 1'b1;
        else if (f7 == F7_ALT) begin
          ok = (f3 == 3'b000) || (f3 == 3'b101);
          c.alu = (f3 == 3'b000) ? ALU_SUB : ALU_SRA;
        end
      end
      OPC_FENCE: begin
        ok      = (f3 == 3'b000);
        c.fence = 1'b1;
      end
      OPC_SYSTEM: begin
        if (f3 == 3'b000) begin
          ok    = (inst == W_ENV_CALL) || (inst == W_ENV_BREAK) ||
                  (inst == W_TRAP_RET) || (inst == W_WAIT_INT);
          c.csr = CS_INSN;
        end else if (f3[1:0] != 2'b00) begin
          ok      = 1'b1;
          c.wr_rd = 1'b1;
          c.alu   = ALU_ADD;
          c.csr   = csr_e'({1'b0, f3[1:0]});
          if (f3[2]) begin
            c.op1 = OP1_ZERO;
            c.op2 = OP2_IMM;
            c.imm = IMM_Z;
          end else begin
            c.rd_rs1 = 1'b1;
            c.op1    = OP1_RS1;
            c.op2    = OP2_ZERO;
          end
        end
      end
      default: ok = 1'b0;
    endcase
  end

  always_comb begin
    ctl = '0;
    if (ok) begin
      ctl       = c;
      ctl.legal = 1'b1;
    end
  end
endmodule

// File: rtl/icd_stage.sv
module icd_stage #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         flush,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic         v_q, v_nx;
  logic [W-1:0] d_q;
  logic         d_en;

  assign d_en = ~hold;

  always_comb begin
    if (flush)     v_nx = 1'b0;
    else if (hold) v_nx = v_q;
    else           v_nx = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    d_q <= '0;
    else if (d_en) d_q <= in_data;
  end

  assign out_valid = v_q;
  assign out_data  = d_q;
endmodule

// File: rtl/icd_ctrl_decode.sv
module icd_ctrl_decode
  import icd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [ILEN-1:0]   id_inst,
  input  logic [NSTAGE-1:0] stall,
  input  logic              flush,
  output logic              dec_legal,
  output logic              dec_branch,
  output logic              dec_jal,
  output logic              dec_jalr,
  output logic              dec_rd_rs1,
  output logic              dec_rd_rs2,
  output logic              dec_wr_rd,
  output logic [1:0]        dec_op1_sel,
  output logic [1:0]        dec_op2_sel,
  output logic [2:0]        dec_imm_sel,
  output logic [3:0]        dec_alu_fn,
  output logic              dec_mem_en,
  output logic [1:0]        dec_mem_cmd,
  output logic [2:0]        dec_csr_cmd,
  output logic              dec_fence,
  output logic              ex_valid,
  output logic [SZ_W-1:0]   ex_size,
  output logic              ex_signed,
  output logic              mem_valid,
  output logic [SZ_W-1:0]   mem_size,
  output logic              mem_signed,
  output logic              wb_valid,
  output logic [SZ_W-1:0]   wb_size,
  output logic              wb_signed
);
  ctrl_t            ctl;
  logic [NSTAGE:0]  vchain;
  logic [PAY_W-1:0] dchain [NSTAGE+1];

  icd_decoder u_dec (
    .inst (id_inst),
    .ctl  (ctl)
  );

  assign dec_legal   = ctl.legal;
  assign dec_branch  = ctl.branch;
  assign dec_jal     = ctl.jal;
  assign dec_jalr    = ctl.jalr;
  assign dec_rd_rs1  = ctl.rd_rs1;
  assign dec_rd_rs2  = ctl.rd_rs2;
  assign dec_wr_rd   = ctl.wr_rd;
  assign dec_op1_sel = ctl.op1;
  assign dec_op2_sel = ctl.op2;
  assign dec_imm_sel = ctl.imm;
  assign dec_alu_fn  = ctl.alu;
  assign dec_mem_en  = ctl.mem_en;
  assign dec_mem_cmd = ctl.mem_cmd;
  assign dec_csr_cmd = ctl.csr;
  assign dec_fence   = ctl.fence;

  assign vchain[0] = id_valid;
  assign dchain[0] = {~id_inst[14], id_inst[12 +: SZ_W]};

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stg
    icd_stage #(.W(PAY_W)) u_stg (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (stall[k]),
      .flush     (flush),
      .in_valid  (vchain[k]),
      .in_data   (dchain[k]),
      .out_valid (vchain[k+1]),
      .out_data  (dchain[k+1])
    );
  end

  assign ex_valid   = vchain[1];
  assign ex_size    = dchain[1][SZ_W-1:0];
  assign ex_signed  = dchain[1][SZ_W];
  assign mem_valid  = vchain[2];
  assign mem_size   = dchain[2][SZ_W-1:0];
  assign mem_signed = dchain[2][SZ_W];
  assign wb_valid   = vchain[3];
  assign wb_size    = dchain[3][SZ_W-1:0];
  assign wb_signed  = dchain[3][SZ_W];
endmodule

// File: rtl/icd_checker.sv
module icd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] id_inst,
  input logic [2:0]  stall,
  input logic        flush,
  input logic        dec_legal,
  input logic        dec_branch,
  input logic        dec_jal,
  input logic        dec_jalr,
  input logic        dec_rd_rs1,
  input logic        dec_rd_rs2,
  input logic        dec_wr_rd,
  input logic [2:0]  dec_imm_sel,
  input logic        dec_mem_en,
  input logic [1:0]  dec_mem_cmd,
  input logic [2:0]  dec_csr_cmd,
  input logic        dec_fence,
  input logic        ex_valid,
  input logic [1:0]  ex_size,
  input logic        ex_signed,
  input logic        mem_valid,
  input logic [1:0]  mem_size,
  input logic        mem_signed,
  input logic        wb_valid,
  input logic [1:0]  wb_size,
  input logic        wb_signed
);
  // R10: an unmatched word has no side effects
  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_legal |-> !(dec_wr_rd || dec_mem_en || dec_branch || dec_jal || dec_jalr ||
                     dec_fence || dec_rd_rs1 || dec_rd_rs2) && dec_csr_cmd == 3'd0);

  // R1: branches read both sources, use the B format and never write rd
  p_branch_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_branch |-> dec_rd_rs1 && dec_rd_rs2 && !dec_wr_rd && dec_imm_sel == 3'd3);

  // R5: stores read rs2 and do not write rd
  p_store_no_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_mem_cmd == 2'd2) |-> dec_mem_en && dec_rd_rs2 && !dec_wr_rd);

  // R6: the custom load opcode with funct3 000 reads memory and writes rd
  p_custom_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_inst[6:0] == 7'b0011111 && id_inst[14:12] == 3'b000) |->
      dec_legal && dec_mem_en && dec_mem_cmd == 2'd1 && dec_wr_rd);

  // R11: execute captures size and inverse of bit 14
  p_ex_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !stall[0] |=> ex_size == $past(id_inst[13:12]) && ex_signed == !$past(id_inst[14]));

  // R12: memory stage takes execute stage contents
  p_mem_adv_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall[1] && !flush) |=> mem_valid == $past(ex_valid) && mem_size == $past(ex_size) &&
                              mem_signed == $past(ex_signed));

  // R12: stalled writeback holds
  p_wb_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stall[2] && !flush) |=> $stable(wb_valid) && $stable(wb_size) && $stable(wb_signed));

  // R13: flush empties every stage
  p_flush_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ex_valid && !mem_valid && !wb_valid);
endmodule

bind icd_ctrl_decode icd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .id_inst(id_inst), .stall(stall), .flush(flush),
  .dec_legal(dec_legal), .dec_branch(dec_branch), .dec_jal(dec_jal), .dec_jalr(dec_jalr),
  .dec_rd_rs1(dec_rd_rs1), .dec_rd_rs2(dec_rd_rs2), .dec_wr_rd(dec_wr_rd),
  .dec_imm_sel(dec_imm_sel), .dec_mem_en(dec_mem_en), .dec_mem_cmd(dec_mem_cmd),
  .dec_csr_cmd(dec_csr_cmd), .dec_fence(dec_fence),
  .ex_valid(ex_valid), .ex_size(ex_size), .ex_signed(ex_signed),
  .mem_valid(mem_valid), .mem_size(mem_size), .mem_signed(mem_signed),
  .wb_valid(wb_valid), .wb_size(wb_size), .wb_signed(wb_signed)
);

// File: tb/tb_icd_ctrl_decode.sv
module tb_icd_ctrl_decode;
  import icd_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_valid = 1'b0;
  logic [31:0] id_inst = 32'h0;
  logic [2:0]  stall = 3'b0;
  logic        flush = 1'b0;
  logic dec_legal, dec_branch, dec_jal, dec_jalr, dec_rd_rs1, dec_rd_rs2, dec_wr_rd;
  logic [1:0] dec_op1_sel, dec_op2_sel, dec_mem_cmd;
  logic [2:0] dec_imm_sel, dec_csr_cmd;
  logic [3:0] dec_alu_fn;
  logic dec_mem_en, dec_fence;
  logic ex_valid, ex_signed, mem_valid, mem_signed, wb_valid, wb_signed;
  logic [1:0] ex_size, mem_size, wb_size;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  ctrl_t dq[$];
  string tq[$];

  logic [2:0] m_v;
  logic [2:0] m_d0, m_d1, m_d2;

  always #(CLK_PERIOD/2) clk = ~clk;

  icd_ctrl_decode dut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_inst(id_inst), .stall(stall),
    .flush(flush), .dec_legal(dec_legal), .dec_branch(dec_branch), .dec_jal(dec_jal),
    .dec_jalr(dec_jalr), .dec_rd_rs1(dec_rd_rs1), .dec_rd_rs2(dec_rd_rs2),
    .dec_wr_rd(dec_wr_rd), .dec_op1_sel(dec_op1_sel), .dec_op2_sel(dec_op2_sel),
    .dec_imm_sel(dec_imm_sel), .dec_alu_fn(dec_alu_fn), .dec_mem_en(dec_mem_en),
    .dec_mem_cmd(dec_mem_cmd), .dec_csr_cmd(dec_csr_cmd), .dec_fence(dec_fence),
    .ex_valid(ex_valid), .ex_size(ex_size), .ex_signed(ex_signed),
    .mem_valid(mem_valid), .mem_size(mem_size), .mem_signed(mem_signed),
    .wb_valid(wb_valid), .wb_size(wb_size), .wb_signed(wb_signed)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rs2,
                                     input logic [4:0] rs1, input logic [2:0] f3,
                                     input logic [4:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic ctrl_t e_br(input alu_e f);
    ctrl_t e = '0;
    e.legal = 1; e.branch = 1; e.rd_rs1 = 1; e.rd_rs2 = 1;
    e.op1 = OP1_RS1; e.op2 = OP2_RS2; e.imm = IMM_B; e.alu = f;
    return e;
  endfunction

  function automatic ctrl_t e_ld();
    ctrl_t e = '0;
    e.legal = 1; e.rd_rs1 = 1; e.wr_rd = 1; e.op1 = OP1_RS1; e.op2 = OP2_IMM;
    e.imm = IMM_I; e.alu = ALU_ADD; e.mem_en = 1; e.mem_cmd = MC_READ;
    return e;
  endfunction

  function automatic ctrl_t e_st();
    ctrl_t e = '0;
    e.legal = 1; e.rd_rs1 = 1; e.rd_rs2 = 1; e.op1 = OP1_RS1; e.op2 = OP2_IMM;
    e.imm = IMM_S; e.alu = ALU_ADD; e.mem_en = 1; e.mem_cmd = MC_WRITE;
    return e;
  endfunction

  function automatic ctrl_t e_ari(input alu_e f, input bit regs);
    ctrl_t e = '0;
    e.legal = 1; e.rd_rs1 = 1; e.wr_rd = 1; e.op1 = OP1_RS1; e.alu = f;
    e.rd_rs2 = regs; e.op2 = regs ? OP2_RS2 : OP2_IMM; e.imm = regs ? IMM_NONE : IMM_I;
    return e;
  endfunction

  function automatic ctrl_t e_csr(input csr_e cmd, input bit immf);
    ctrl_t e = '0;
    e.legal = 1; e.wr_rd = 1; e.alu = ALU_ADD; e.csr = cmd;
    if (immf) begin e.op1 = OP1_ZERO; e.op2 = OP2_IMM; e.imm = IMM_Z; end
    else begin e.rd_rs1 = 1; e.op1 = OP1_RS1; e.op2 = OP2_ZERO; end
    return e;
  endfunction

  function automatic ctrl_t e_sys();
    ctrl_t e = '0;
    e.legal = 1; e.csr = CS_INSN;
    return e;
  endfunction

  // driver: push expectation, drive word for the next edge
  task automatic send(input logic [31:0] w, input ctrl_t e, input string tag);
    @(negedge clk);
    id_inst = w;
    id_valid = 1'b1;
    dq.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic step(input logic [31:0] w, input logic v, input logic [2:0] st, input logic fl);
    @(negedge clk);
    id_inst = w; id_valid = v; stall = st; flush = fl;
  endtask

  // scoreboard monitor for the decode bundle
  always @(posedge clk) begin
    #1;
    if (dq.size() > 0) begin
      ctrl_t e;
      ctrl_t g;
      string t;
      e = dq.pop_front();
      t = tq.pop_front();
      g.legal = dec_legal; g.branch = dec_branch; g.jal = dec_jal; g.jalr = dec_jalr;
      g.rd_rs1 = dec_rd_rs1; g.rd_rs2 = dec_rd_rs2; g.wr_rd = dec_wr_rd;
      g.op1 = op1_e'(dec_op1_sel); g.op2 = op2_e'(dec_op2_sel); g.imm = imm_e'(dec_imm_sel);
      g.alu = alu_e'(dec_alu_fn); g.mem_en = dec_mem_en; g.mem_cmd = mcmd_e'(dec_mem_cmd);
      g.csr = csr_e'(dec_csr_cmd); g.fence = dec_fence;
      chk(g === e, t, 32'(g), 32'(e));
    end
  end

  // stage reference built from R11..R13
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_v <= '0; m_d0 <= '0; m_d1 <= '0; m_d2 <= '0;
    end else begin
      if (!stall[0]) m_d0 <= {~id_inst[14], id_inst[13:12]};
      if (!stall[1]) m_d1 <= m_d0;
      if (!stall[2]) m_d2 <= m_d1;
      if (flush) m_v <= '0;
      else begin
        if (!stall[0]) m_v[0] <= id_valid;
        if (!stall[1]) m_v[1] <= m_v[0];
        if (!stall[2]) m_v[2] <= m_v[1];
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk({ex_valid, mem_valid, wb_valid} === {m_v[0], m_v[1], m_v[2]}, "R12 R13 valid bits",
          32'({ex_valid, mem_valid, wb_valid}), 32'({m_v[0], m_v[1], m_v[2]}));
      chk({ex_signed, ex_size} === m_d0, "R11 execute size/sign",
          32'({ex_signed, ex_size}), 32'(m_d0));
      if (m_v[1]) chk({mem_signed, mem_size} === m_d1, "R12 memory size/sign",
                      32'({mem_signed, mem_size}), 32'(m_d1));
      if (m_v[2]) chk({wb_signed, wb_size} === m_d2, "R12 writeback size/sign",
                      32'({wb_signed, wb_size}), 32'(m_d2));
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    ctrl_t e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk({ex_valid, mem_valid, wb_valid, ex_size, mem_size, wb_size} === 9'b0, "R13 reset state",
        32'({ex_valid, mem_valid, wb_valid}), 32'd0);

    // R1 R2 branches
    send(mk(7'h00, 5'd2, 5'd1, 3'b000, 5'd0, OPC_BRANCH), e_br(ALU_EQ),   "R1 R2 beq");
    send(mk(7'h10, 5'd3, 5'd4, 3'b001, 5'd8, OPC_BRANCH), e_br(ALU_NE),   "R2 bne");
    send(mk(7'h00, 5'd2, 5'd1, 3'b100, 5'd0, OPC_BRANCH), e_br(ALU_SLT),  "R2 blt");
    send(mk(7'h00, 5'd2, 5'd1, 3'b101, 5'd0, OPC_BRANCH), e_br(ALU_GE),   "R2 bge");
    send(mk(7'h00, 5'd2, 5'd1, 3'b110, 5'd0, OPC_BRANCH), e_br(ALU_SLTU), "R2 bltu");
    send(mk(7'h00, 5'd2, 5'd1, 3'b111, 5'd0, OPC_BRANCH), e_br(ALU_GEU),  "R2 bgeu");
    send(mk(7'h00, 5'd2, 5'd1, 3'b010, 5'd0, OPC_BRANCH), '0, "R2 branch funct3 010 illegal");
    // R3 jumps
    e = '0; e.legal = 1; e.jal = 1; e.wr_rd = 1; e.op1 = OP1_PC; e.op2 = OP2_ISZ; e.imm = IMM_J;
    send(32'h0100_00EF, e, "R3 jal");
    e = '0; e.legal = 1; e.jalr = 1; e.rd_rs1 = 1; e.wr_rd = 1; e.op1 = OP1_RS1; e.op2 = OP2_IMM;
    e.imm = IMM_I;
    send(mk(7'h00, 5'd4, 5'd5, 3'b000, 5'd1, OPC_JALR), e, "R3 jalr");
    send(mk(7'h00, 5'd4, 5'd5, 3'b001, 5'd1, OPC_JALR), '0, "R3 jalr funct3 001 illegal");
    // R4 upper immediates
    e = '0; e.legal = 1; e.wr_rd = 1; e.op1 = OP1_ZERO; e.op2 = OP2_IMM; e.imm = IMM_U;
    send(32'h1234_52B7, e, "R4 lui");
    e.op1 = OP1_PC;
    send(32'h1234_5297, e, "R4 auipc");
    // R5 loads and stores
    send(mk(7'h00, 5'd0, 5'd1, 3'b000, 5'd2, OPC_LOAD), e_ld(), "R5 lb");
    send(mk(7'h00, 5'd0, 5'd1, 3'b001, 5'd2, OPC_LOAD), e_ld(), "R5 lh");
    send(mk(7'h00, 5'd0, 5'd1, 3'b010, 5'd2, OPC_LOAD), e_ld(), "R5 lw");
    send(mk(7'h00, 5'd0, 5'd1, 3'b100, 5'd2, OPC_LOAD), e_ld(), "R5 lbu");
    send(mk(7'h00, 5'd0, 5'd1, 3'b101, 5'd2, OPC_LOAD), e_ld(), "R5 lhu");
    send(mk(7'h00, 5'd0, 5'd1, 3'b011, 5'd2, OPC_LOAD), '0, "R5 load funct3 011 illegal");
    send(mk(7'h00, 5'd6, 5'd1, 3'b000, 5'd2, OPC_STORE), e_st(), "R5 sb");
    send(mk(7'h00, 5'd6, 5'd1, 3'b001, 5'd2, OPC_STORE), e_st(), "R5 sh");
    send(mk(7'h00, 5'd6, 5'd1, 3'b010, 5'd2, OPC_STORE), e_st(), "R5 sw");
    send(mk(7'h00, 5'd6, 5'd1, 3'b100, 5'd2, OPC_STORE), '0, "R5 store funct3 100 illegal");
    // R6 custom load
    send(mk(7'h55, 5'd9, 5'd3, 3'b000, 5'd7, OPC_XLOAD), e_ld(), "R6 custom load");
    send(mk(7'h00, 5'd0, 5'd3, 3'b001, 5'd7, OPC_XLOAD), '0, "R6 custom funct3 001 illegal");
    // R7 ALU
    send(mk(7'h00, 5'd0, 5'd1, 3'b000, 5'd2, OPC_ARI_I), e_ari(ALU_ADD, 0),  "R7 addi");
    send(mk(7'h3F, 5'd0, 5'd1, 3'b010, 5'd2, OPC_ARI_I), e_ari(ALU_SLT, 0),  "R7 slti");
    send(mk(7'h00, 5'd0, 5'd1, 3'b100, 5'd2, OPC_ARI_I), e_ari(ALU_XOR, 0),  "R7 xori");
    send(mk(7'h00, 5'd3, 5'd1, 3'b001, 5'd2, OPC_ARI_I), e_ari(ALU_SLL, 0),  "R7 slli");
    send(mk(7'h20, 5'd3, 5'd1, 3'b101, 5'd2, OPC_ARI_I), e_ari(ALU_SRA, 0),  "R7 srai");
    send(mk(7'h01, 5'd3, 5'd1, 3'b001, 5'd2, OPC_ARI_I), '0, "R7 slli bad funct7 illegal");
    send(mk(7'h00, 5'd3, 5'd1, 3'b000, 5'd2, OPC_ARI_R), e_ari(ALU_ADD, 1),  "R7 add");
    send(mk(7'h20, 5'd3, 5'd1, 3'b000, 5'd2, OPC_ARI_R), e_ari(ALU_SUB, 1),  "R7 sub");
    send(mk(7'h20, 5'd3, 5'd1, 3'b101, 5'd2, OPC_ARI_R), e_ari(ALU_SRA, 1),  "R7 sra");
    send(mk(7'h00, 5'd3, 5'd1, 3'b111, 5'd2, OPC_ARI_R), e_ari(ALU_AND, 1),  "R7 and");
    send(mk(7'h00, 5'd3, 5'd1, 3'b011, 5'd2, OPC_ARI_R), e_ari(ALU_SLTU, 1), "R7 sltu");
    send(mk(7'h20, 5'd3, 5'd1, 3'b100, 5'd2, OPC_ARI_R), '0, "R7 alt xor illegal");
    send(mk(7'h01, 5'd3, 5'd1, 3'b000, 5'd2, OPC_ARI_R), '0, "R7 funct7 0000001 illegal");
    // R8 CSR
    send(mk(7'h18, 5'd0, 5'd1, 3'b001, 5'd2, OPC_SYSTEM), e_csr(CS_WRITE, 0), "R8 csrrw");
    send(mk(7'h18, 5'd0, 5'd1, 3'b011, 5'd2, OPC_SYSTEM), e_csr(CS_CLEAR, 0), "R8 csrrc");
    send(mk(7'h18, 5'd0, 5'd1, 3'b110, 5'd2, OPC_SYSTEM), e_csr(CS_SET, 1),   "R8 csrrsi");
    send(mk(7'h18, 5'd0, 5'd1, 3'b111, 5'd2, OPC_SYSTEM), e_csr(CS_CLEAR, 1), "R8 csrrci");
    send(mk(7'h18, 5'd0, 5'd1, 3'b100, 5'd2, OPC_SYSTEM), '0, "R8 system funct3 100 illegal");
    // R9 system words and fence
    send(32'h0000_0073, e_sys(), "R9 env call");
    send(32'h0010_0073, e_sys(), "R9 env break");
    send(32'h3020_0073, e_sys(), "R9 trap return");
    send(32'h1050_0073, e_sys(), "R9 wait");
    send(32'h0020_0073, '0, "R9 unknown system word illegal");
    e = '0; e.legal = 1; e.fence = 1;
    send(32'h0FF0_000F, e, "R9 fence");
    // R10 no match
    send(32'h0000_0000, '0, "R10 zero word");
    send(32'hFFFF_FFFF, '0, "R10 ones word");
    send(mk(7'h00, 5'd0, 5'd1, 3'b000, 5'd2, 7'b1011011), '0, "R10 unused opcode");

    // R11 R12 R13 stall and flush patterns
    for (int i = 0; i < 60; i++) begin
      step(mk(7'h00, 5'd0, 5'd1, 3'(i * 3), 5'd2, OPC_LOAD), (i % 5) != 3,
           {(i % 9) == 5, (i % 6) == 4, (i % 7) == 2}, (i % 11) == 7);
    end
    for (int i = 0; i < 4; i++) step(32'h0, 1'b0, 3'b000, (i == 1));
    step(32'h0, 1'b0, 3'b111, 1'b1);
    step(32'h0, 1'b0, 3'b000, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule